// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the fetch front end of a small pipelined core whose instructions are one, two, nine or ten bytes long. From the current fetch address it reads a window of instruction bytes out of a small local byte store. It splits the leading byte into an operation code and a function code. When the operation calls for them, it also picks up a register-pair byte and a little-endian 64-bit constant. It then produces the address of the next sequential instruction. Decoding is purely combinational from the fetch address to every decoded output, so the pipeline register that follows can capture the results in the same cycle.

The block also classifies each fetch: address fault, illegal operation, halt or normal. It gives a matching status to the next-address stage, which sees a bubble for anything other than a normal fetch. When the address is faulted, the operation and function fields presented downstream are forced to a no-operation encoding. The local store is filled through a byte-wide load stream. That stream has a valid/ready handshake whose ready is held high, so a producer never sees back-pressure and every beat presented with valid is accepted on that clock edge.

Top module: `fetch_decoder`

## Requirements
- R1: With no address fault, `icode` is bits 7:4 and `ifun` is bits 3:0 of the byte at `pc`.
- R2: For operation codes 2, 3, 4, 5, 6, 0xA and 0xB, the byte at `pc+1` supplies `ra` (bits 7:4) and `rb` (bits 3:0). For every other code, both read 0xF.
- R3: For operation codes 3, 4, 5, 7 and 8, `valc` is the 8 bytes that follow the optional register byte, least significant byte first. For every other code, `valc` is zero.
- R4: `valp` equals `pc + 1`, plus 1 when a register byte is present, plus 8 when a constant is present.
- R5: An address fault occurs when `pc` or `pc+5` is not below the store depth (64 by default). On a fault, `icode` reads 1 and `ifun` reads 0.
- R6: An operation code above 0xB yields the illegal-operation status.
- R7: Operation code 0 yields the halt status.
- R8: `f_stat` encodes normal=1, halt=2, address fault=3 and illegal=4. Address fault takes priority over illegal, illegal over halt, and halt over normal.
- R9: `pc_stat` is 1 (normal) when `f_stat` is normal, and 0 (bubble) otherwise.
- R10: A load beat (`ld_valid` high, `ld_ready` always high) writes `ld_data` to byte `ld_addr` at the clock edge. Reset clears every byte to zero. Any byte of the fetch window that lies beyond the store reads as zero.
- R11: A load beat whose `ld_addr` is not below the store depth changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the byte store |
| rst_n | input | 1 | Active-low synchronous reset; clears the store |
| ld_valid | input | 1 | Load beat present |
| ld_ready | output | 1 | Load beat accepted; always high |
| ld_addr | input | 8 | Byte address of the load beat |
| ld_data | input | 8 | Byte written by the load beat |
| pc | input | 64 | Fetch address |
| icode | output | 4 | Operation code presented downstream |
| ifun | output | 4 | Function code presented downstream |
| ra | output | 4 | First register specifier or 0xF |
| rb | output | 4 | Second register specifier or 0xF |
| valc | output | 64 | Constant field or zero |
| valp | output | 64 | Fall-through address |
| f_stat | output | 3 | Fetch status |
| pc_stat | output | 3 | Status for the next-address stage |

## Verification
The assertions assume that `ld_valid`, `ld_addr`, `ld_data` and `pc` carry known values whenever reset is released, and that at most one byte is loaded per cycle. The length and field checks also assume `pc` is stable around a rising edge, because the decode path has no register. The stimulus changes `pc` and the load signals only on falling edges and drops `ld_valid` after each single-beat load. It samples decoded outputs a short delay after `pc` changes, so every sample sees settled combinational values and a store that is no longer being written.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int WIN_BYTES   = 10;
  localparam int CONST_BYTES = 8;
  localparam int CONST_W     = CONST_BYTES * 8;
  localparam int ADR_PROBE   = 5;

  localparam logic [3:0] REG_NONE   = 4'hF;
  localparam logic [3:0] OP_HALT    = 4'h0;
  localparam logic [3:0] OP_NOP     = 4'h1;
  localparam logic [3:0] FN_NONE    = 4'h0;
  localparam logic [3:0] OP_LAST_OK = 4'hB;

  typedef enum logic [2:0] {
    ST_BUB = 3'd0,
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } fstat_e;

  function automatic logic op_has_regs(input logic [3:0] op);
    case (op)
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: op_has_regs = 1'b1;
      default:                                  op_has_regs = 1'b0;
    endcase
  endfunction

  function automatic logic op_has_const(input logic [3:0] op);
    case (op)
      4'h3, 4'h4, 4'h5, 4'h7, 4'h8: op_has_const = 1'b1;
      default:                      op_has_const = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fd_imem.sv
module fd_imem
  import fd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PC_W  = 64,
  parameter int LD_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  input  logic [LD_AW-1:0]          ld_addr,
  input  logic [7:0]                ld_data,
  input  logic [PC_W-1:0]           pc,
  output logic [WIN_BYTES*8-1:0]    win_flat,
  output logic                      adr_err
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LD_AW:0] DEPTH_LD = (LD_AW+1)'(DEPTH);
  localparam logic [PC_W:0]  DEPTH_PC = (PC_W+1)'(DEPTH);

  logic [7:0] store [DEPTH];
  logic       ld_in_rng;
  logic [WIN_BYTES-1:0] rd_in_rng;

  assign ld_ready  = 1'b1;
  assign ld_in_rng = {1'b0, ld_addr} < DEPTH_LD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= 8'h00;
    end else if (ld_valid && ld_in_rng) begin
      store[ld_addr[IDX_W-1:0]] <= ld_data;
    end
  end

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_rd
    logic [PC_W:0] rd_addr;
    assign rd_addr      = {1'b0, pc} + (PC_W+1)'(k);
    assign rd_in_rng[k] = rd_addr < DEPTH_PC;
    assign win_flat[8*k +: 8] = rd_in_rng[k] ? store[rd_addr[IDX_W-1:0]] : 8'h00;
  end

  assign adr_err = !rd_in_rng[0] || !rd_in_rng[ADR_PROBE];

  // R10
  load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_in_rng) |=> (store[$past(ld_addr[IDX_W-1:0])] == $past(ld_data)));
endmodule

// File: rtl/fd_field_split.sv
module fd_field_split
  import fd_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic [WIN_BYTES*8-1:0] win_flat,
  input  logic [PC_W-1:0]        pc,
  output logic [3:0]             op_raw,
  output logic [3:0]             fn_raw,
  output logic [3:0]             ra,
  output logic [3:0]             rb,
  output logic [CONST_W-1:0]     valc,
  output logic [PC_W-1:0]        valp
);
  logic has_regs;
  logic has_const;
  logic [PC_W-1:0] len;

  assign op_raw    = win_flat[7:4];
  assign fn_raw    = win_flat[3:0];
  assign has_regs  = op_has_regs(op_raw);
  assign has_const = op_has_const(op_raw);

  always_comb begin
    if (has_regs) begin
      ra = win_flat[15:12];
      rb = win_flat[11:8];
    end else begin
      ra = REG_NONE;
      rb = REG_NONE;
    end
    if (!has_const)     valc = '0;
    else if (has_regs)  valc = win_flat[16 +: CONST_W];
    else                valc = win_flat[8 +: CONST_W];
  end

  assign len  = PC_W'(1) + PC_W'(has_regs) + (has_const ? PC_W'(CONST_BYTES) : PC_W'(0));
  assign valp = pc + len;
endmodule

// File: rtl/fd_status.sv
module fd_status
  import fd_pkg::*;
(
  input  logic       adr_err,
  input  logic [3:0] op_raw,
  output logic [2:0] f_stat,
  output logic [2:0] pc_stat
);
  fstat_e st;

  always_comb begin
    if (adr_err)                 st = ST_ADR;
    else if (op_raw > OP_LAST_OK) st = ST_INS;
    else if (op_raw == OP_HALT)  st = ST_HLT;
    else                         st = ST_AOK;
  end

  assign f_stat  = st;
  assign pc_stat = (st == ST_AOK) ? ST_AOK : ST_BUB;
endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
  import fd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PC_W  = 64,
  parameter int LD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [7:0]         ld_data,
  input  logic [PC_W-1:0]    pc,
  output logic [3:0]         icode,
  output logic [3:0]         ifun,
  output logic [3:0]         ra,
  output logic [3:0]         rb,
  output logic [CONST_W-1:0] valc,
  output logic [PC_W-1:0]    valp,
  output logic [2:0]         f_stat,
  output logic [2:0]         pc_stat
);
  logic [WIN_BYTES*8-1:0] win_flat;
  logic                   adr_err;
  logic [3:0]             op_raw;
  logic [3:0]             fn_raw;
  logic [PC_W-1:0]        span;

  fd_imem #(.DEPTH(DEPTH), .PC_W(PC_W), .LD_AW(LD_AW)) u_imem (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc),
    .win_flat(win_flat), .adr_err(adr_err)
  );

  fd_field_split #(.PC_W(PC_W)) u_split (
    .win_flat(win_flat), .pc(pc), .op_raw(op_raw), .fn_raw(fn_raw),
    .ra(ra), .rb(rb), .valc(valc), .valp(valp)
  );

  fd_status u_stat (
    .adr_err(adr_err), .op_raw(op_raw), .f_stat(f_stat), .pc_stat(pc_stat)
  );

  assign icode = adr_err ? OP_NOP  : op_raw;
  assign ifun  = adr_err ? FN_NONE : fn_raw;

  assign span = valp - pc;

  // R4
  valp_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (span == PC_W'(1)) || (span == PC_W'(2)) || (span == PC_W'(9)) || (span == PC_W'(10)));

  // R2
  regs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ra != REG_NONE) || (rb != REG_NONE)) |-> ((span == PC_W'(2)) || (span == PC_W'(10))));

  // R3
  valc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((span == PC_W'(1)) || (span == PC_W'(2))) |-> (valc == '0));

  // R5
  adr_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_stat == ST_ADR) |-> ((icode == OP_NOP) && (ifun == FN_NONE)));

  // R9
  next_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_stat == ST_AOK) == (pc_stat == ST_AOK)) && ((pc_stat == ST_AOK) || (pc_stat == ST_BUB)));
endmodule

// File: tb/fetch_decoder_tb.sv
module fetch_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [7:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [63:0] pc = '0;
  logic [3:0]  icode, ifun, ra, rb;
  logic [63:0] valc, valp;
  logic [2:0]  f_stat, pc_stat;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fetch_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc),
    .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .valc(valc), .valp(valp), .f_stat(f_stat), .pc_stat(pc_stat)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = a;
    ld_data  = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic fetch(input logic [63:0] a);
    @(negedge clk);
    pc = a;
    #1;
  endtask

  task automatic t_reset_state();
    fetch(64'd4);
    chk("R10 reset clears store icode", {60'd0, icode}, 64'h0);
    chk("R7 halt status after reset", {61'd0, f_stat}, 64'd2);
    chk("R9 bubble on halt", {61'd0, pc_stat}, 64'd0);
    chk("R4 halt length", valp, 64'd5);
    chk("R10 ready high", {63'd0, ld_ready}, 64'd1);
  endtask

  task automatic t_halt_nop();
    put(8'd0, 8'h00);
    put(8'd1, 8'h10);
    fetch(64'd1);
    chk("R1 nop icode", {60'd0, icode}, 64'h1);
    chk("R2 nop ra none", {60'd0, ra}, 64'hF);
    chk("R2 nop rb none", {60'd0, rb}, 64'hF);
    chk("R4 nop valp", valp, 64'd2);
    chk("R8 nop normal", {61'd0, f_stat}, 64'd1);
    chk("R9 nop next stat", {61'd0, pc_stat}, 64'd1);
  endtask

  task automatic t_regmove();
    put(8'd2, 8'h25);
    put(8'd3, 8'h3A);
    fetch(64'd2);
    chk("R1 cmov icode", {60'd0, icode}, 64'h2);
    chk("R1 cmov ifun", {60'd0, ifun}, 64'h5);
    chk("R2 cmov ra", {60'd0, ra}, 64'h3);
    chk("R2 cmov rb", {60'd0, rb}, 64'hA);
    chk("R3 cmov valc zero", valc, 64'h0);
    chk("R4 cmov valp", valp, 64'd4);
  endtask

  task automatic t_imm_with_regs();
    put(8'd4, 8'h30);
    put(8'd5, 8'hF2);
    for (int i = 0; i < 8; i++) put(8'(6 + i), 8'((i + 1) * 8'h11));
    fetch(64'd4);
    chk("R2 imm ra", {60'd0, ra}, 64'hF);
    chk("R2 imm rb", {60'd0, rb}, 64'h2);
    chk("R3 imm constant", valc, 64'h8877665544332211);
    chk("R4 imm valp", valp, 64'd14);
  endtask

  task automatic t_jump();
    put(8'd14, 8'h70);
    for (int i = 0; i < 8; i++) put(8'(15 + i), 8'(i + 1));
    fetch(64'd14);
    chk("R3 jump constant", valc, 64'h0807060504030201);
    chk("R2 jump ra none", {60'd0, ra}, 64'hF);
    chk("R4 jump valp", valp, 64'd23);
  endtask

  task automatic t_invalid_and_ret();
    put(8'd23, 8'hC0);
    put(8'd24, 8'h90);
    fetch(64'd23);
    chk("R6 illegal status", {61'd0, f_stat}, 64'd4);
    chk("R9 illegal bubble", {61'd0, pc_stat}, 64'd0);
    chk("R4 illegal valp", valp, 64'd24);
    fetch(64'd24);
    chk("R8 ret normal", {61'd0, f_stat}, 64'd1);
    chk("R4 ret valp", valp, 64'd25);
  endtask

  task automatic t_alu();
    put(8'd40, 8'h61);
    put(8'd41, 8'h89);
    fetch(64'd40);
    chk("R1 alu ifun", {60'd0, ifun}, 64'h1);
    chk("R2 alu ra", {60'd0, ra}, 64'h8);
    chk("R2 alu rb", {60'd0, rb}, 64'h9);
    chk("R4 alu valp", valp, 64'd42);
  endtask

  task automatic t_tail_and_fault();
    put(8'd58, 8'h80);
    for (int i = 0; i < 5; i++) put(8'(59 + i), 8'(8'hA1 + i));
    fetch(64'd58);
    chk("R5 last safe pc normal", {61'd0, f_stat}, 64'd1);
    chk("R10 tail bytes zero", valc, 64'h000000A5A4A3A2A1);
    chk("R4 call valp", valp, 64'd67);
    fetch(64'd59);
    chk("R5 probe fault status", {61'd0, f_stat}, 64'd3);
    chk("R5 fault icode nop", {60'd0, icode}, 64'h1);
    chk("R5 fault ifun zero", {60'd0, ifun}, 64'h0);
    chk("R9 fault bubble", {61'd0, pc_stat}, 64'd0);
    put(8'd60, 8'hE0);
    fetch(64'd60);
    chk("R8 fault over illegal", {61'd0, f_stat}, 64'd3);
    fetch(64'd100);
    chk("R5 far pc fault", {61'd0, f_stat}, 64'd3);
  endtask

  task automatic t_oob_load();
    put(8'd64, 8'h55);
    put(8'd128, 8'h66);
    fetch(64'd0);
    chk("R11 byte 0 untouched", {60'd0, icode}, 64'h0);
    chk("R7 halt status", {61'd0, f_stat}, 64'd2);
  endtask

  task automatic t_reset_clears();
    do_reset();
    fetch(64'd2);
    chk("R10 reset clears loaded byte", {60'd0, icode}, 64'h0);
    chk("R10 reset clears ra", {60'd0, ra}, 64'hF);
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_halt_nop();
    t_regmove();
    t_imm_with_regs();
    t_jump();
    t_invalid_and_ret();
    t_alu();
    t_tail_and_fault();
    t_oob_load();
    t_reset_clears();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule